// File: doc/BRIEF.md
# CPU Register File with 16-bit Pair Views

This block is the architectural register store of a small 8-bit processor. It holds seven general byte registers (A, B, C, D, E, H, L), a four-bit condition-flag register, and two full 16-bit registers: the stack pointer and the program counter. An instruction datapath reads and writes single bytes through a byte read port and a byte write port. Through a third port it reads and writes 16-bit register pairs.

The pairs AF, BC, DE and HL are views onto the same byte storage, so there is no second copy to keep in step. SP and PC exist only as 16-bit registers. All reads are combinational. Writes land on the rising clock edge, so a written value is visible from the cycle after the write.

The flag register stores only its four upper bits: zero, subtract, half-carry and carry. Its lower nibble always reads as zero, through the byte view and through the low half of AF.

Top module: `cpu_regfile`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every byte register, the flags, SP and PC are cleared to zero.
- R2: A byte write with `byte_wr_en` high stores `byte_wr_data` into the register that `byte_wr_sel` names (0=A, 1=B, 2=C, 3=D, 4=E, 5=H, 6=L, 7=flags). The value reads back on `byte_rd_data`, combinationally through `byte_rd_sel` (same encoding), from the next cycle on.
- R3: `pair_rd_data` shows the pair that `pair_sel` names (0=AF, 1=BC, 2=DE, 3=HL, 4=SP, 5=PC). For AF, BC, DE and HL, bits 15:8 hold the first-named register and bits 7:0 hold the second-named one.
- R4: A pair write with `pair_wr_en` high stores `pair_wr_data[15:8]` into the pair's high register and `pair_wr_data[7:0]` into its low register on the same edge. The result is visible through the byte read port.
- R5: SP (`pair_sel`=4) and PC (`pair_sel`=5) are full 16-bit registers written and read only through the pair port. No byte write changes them.
- R6: The flag register keeps bits 7:4 of any value written to it, by byte write or as the low half of AF. Bits 3:0 of the flag byte always read as 0.
- R7: When a byte write and a pair write target the same byte register in one cycle, the pair write's value is stored.
- R8: `pair_sel` values 6 and 7 read as 0000h, and a pair write to them changes no register.
- R9: A write changes only the registers it targets. All other registers keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| byte_rd_sel | input | 3 | Byte read select |
| byte_rd_data | output | 8 | Selected byte register value |
| byte_wr_en | input | 1 | Byte write enable |
| byte_wr_sel | input | 3 | Byte write select |
| byte_wr_data | input | 8 | Byte write value |
| pair_sel | input | 3 | Pair select, shared by pair read and pair write |
| pair_rd_data | output | 16 | Selected pair value |
| pair_wr_en | input | 1 | Pair write enable |
| pair_wr_data | input | 16 | Pair write value |

## Verification
Reads are combinational, so a wrong stored value shows at the ports as soon as the matching select is applied, one cycle after the write that caused it. A wrong value can come from swapped pair halves, a write that also lands on a neighbour register, or the wrong winner in a collision. After every write cycle the bench sweeps all eight byte selects and all eight pair selects. Any corruption is therefore caught before the next write can hide it. Flag-nibble leaks show through two separate routes: the byte view and the low half of AF.

// File: rtl/regfile_pkg.sv
// Shared widths, select encodings and the byte-to-pair ownership map for
// the register file. Assumes the byte select order A,B,C,D,E,H,L,F and the
// pair select order AF,BC,DE,HL,SP,PC used by the decode logic.
package regfile_pkg;
    localparam int BYTE_W  = 8;
    localparam int WORD_W  = 2 * BYTE_W;
    localparam int NUM_GP  = 7;
    localparam int SEL_W   = 3;
    localparam int FLAG_W  = 4;

    localparam logic [SEL_W-1:0] BSEL_FLAGS = 3'd7;

    localparam logic [SEL_W-1:0] PSEL_AF = 3'd0;
    localparam logic [SEL_W-1:0] PSEL_BC = 3'd1;
    localparam logic [SEL_W-1:0] PSEL_DE = 3'd2;
    localparam logic [SEL_W-1:0] PSEL_HL = 3'd3;
    localparam logic [SEL_W-1:0] PSEL_SP = 3'd4;
    localparam logic [SEL_W-1:0] PSEL_PC = 3'd5;

    // Pair that owns general byte register idx
    function automatic logic [SEL_W-1:0] owner_pair(input int idx);
        case (idx)
            0:       return PSEL_AF;
            1, 2:    return PSEL_BC;
            3, 4:    return PSEL_DE;
            default: return PSEL_HL;
        endcase
    endfunction

    // True when byte register idx is the upper half of its pair
    function automatic bit is_high_half(input int idx);
        return (idx == 0) || (idx == 1) || (idx == 3) || (idx == 5);
    endfunction
endpackage

// File: rtl/regfile_byte_cell.sv
// One general byte register. It can be written by the byte port or by
// the pair port; the pair port has priority when both fire together.
// Assumes the enables are already decoded for this cell.
module regfile_byte_cell #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_we,
    input  logic [W-1:0] byte_d,
    input  logic         pair_we,
    input  logic [W-1:0] pair_d,
    output logic [W-1:0] q
);
    // Storage update with pair-over-byte priority
    always_ff @(posedge clk) begin
        if (!rst_n)       q <= '0;
        else if (pair_we) q <= pair_d;
        else if (byte_we) q <= byte_d;
    end

    AST_PAIR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we |=> q == $past(pair_d)); // R7
    AST_BYTE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && !pair_we) |=> q == $past(byte_d)); // R2
    AST_BYTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!byte_we && !pair_we) |=> $stable(q)); // R9
endmodule

// File: rtl/regfile_flag_cell.sv
// Condition flag register. It stores only the upper nibble of the value
// written and rebuilds the byte with a zero lower nibble. Same write
// priority as a general byte cell.
module regfile_flag_cell #(
    parameter int W  = 8,
    parameter int FW = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         byte_we,
    input  logic [W-1:0] byte_d,
    input  logic         pair_we,
    input  logic [W-1:0] pair_d,
    output logic [W-1:0] q
);
    localparam int LOW_W = W - FW;

    logic [FW-1:0] flags;
    logic [LOW_W-1:0] unused_low;

    // Keep only the four defined flag bits
    always_ff @(posedge clk) begin
        if (!rst_n)       flags <= '0;
        else if (pair_we) flags <= pair_d[W-1:LOW_W];
        else if (byte_we) flags <= byte_d[W-1:LOW_W];
    end

    // Rebuild the readable byte
    assign q = {flags, {LOW_W{1'b0}}};
    assign unused_low = byte_d[LOW_W-1:0] ^ pair_d[LOW_W-1:0];

    AST_FLAG_PAIR_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        pair_we |=> flags == $past(pair_d[W-1:LOW_W])); // R7
    AST_FLAG_BYTE_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_we && !pair_we) |=> flags == $past(byte_d[W-1:LOW_W])); // R6
endmodule

// File: rtl/regfile_word_cell.sv
// A full-width register (stack pointer or program counter) written only
// through the pair port.
module regfile_word_cell #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Word storage
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= '0;
        else if (we) q <= d;
    end

    AST_WORD_STORE: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> q == $past(d)); // R5
    AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(q)); // R5
endmodule

// File: rtl/cpu_regfile.sv
// Register file top. It decodes the byte and pair write selects into
// per-cell enables and muxes the combinational byte and pair read views.
// Assumes the caller drives selects in the encodings of regfile_pkg.
module cpu_regfile
    import regfile_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [SEL_W-1:0]  byte_rd_sel,
    output logic [BYTE_W-1:0] byte_rd_data,
    input  logic              byte_wr_en,
    input  logic [SEL_W-1:0]  byte_wr_sel,
    input  logic [BYTE_W-1:0] byte_wr_data,
    input  logic [SEL_W-1:0]  pair_sel,
    output logic [WORD_W-1:0] pair_rd_data,
    input  logic              pair_wr_en,
    input  logic [WORD_W-1:0] pair_wr_data
);
    logic [BYTE_W-1:0] byte_view [NUM_GP+1];
    logic [WORD_W-1:0] sp_q, pc_q;

    // General byte registers, each tied to its owning pair half
    for (genvar i = 0; i < NUM_GP; i++) begin : g_gp
        localparam logic [SEL_W-1:0] OWNER = owner_pair(i);
        localparam bit HIGH = is_high_half(i);
        logic bwe, pwe;
        logic [BYTE_W-1:0] pd;
        assign bwe = byte_wr_en && (byte_wr_sel == SEL_W'(i));
        assign pwe = pair_wr_en && (pair_sel == OWNER);
        assign pd  = HIGH ? pair_wr_data[WORD_W-1:BYTE_W] : pair_wr_data[BYTE_W-1:0];
        regfile_byte_cell #(.W(BYTE_W)) u_cell (
            .clk(clk), .rst_n(rst_n),
            .byte_we(bwe), .byte_d(byte_wr_data),
            .pair_we(pwe), .pair_d(pd),
            .q(byte_view[i])
        );
    end

    regfile_flag_cell #(.W(BYTE_W), .FW(FLAG_W)) u_flags (
        .clk(clk), .rst_n(rst_n),
        .byte_we(byte_wr_en && (byte_wr_sel == BSEL_FLAGS)),
        .byte_d(byte_wr_data),
        .pair_we(pair_wr_en && (pair_sel == PSEL_AF)),
        .pair_d(pair_wr_data[BYTE_W-1:0]),
        .q(byte_view[NUM_GP])
    );

    regfile_word_cell #(.W(WORD_W)) u_sp (
        .clk(clk), .rst_n(rst_n),
        .we(pair_wr_en && (pair_sel == PSEL_SP)),
        .d(pair_wr_data), .q(sp_q)
    );

    regfile_word_cell #(.W(WORD_W)) u_pc (
        .clk(clk), .rst_n(rst_n),
        .we(pair_wr_en && (pair_sel == PSEL_PC)),
        .d(pair_wr_data), .q(pc_q)
    );

    // Byte read mux
    assign byte_rd_data = byte_view[byte_rd_sel];

    // Pair read mux: first-named register in the upper byte
    always_comb begin
        case (pair_sel)
            PSEL_AF: pair_rd_data = {byte_view[0], byte_view[7]};
            PSEL_BC: pair_rd_data = {byte_view[1], byte_view[2]};
            PSEL_DE: pair_rd_data = {byte_view[3], byte_view[4]};
            PSEL_HL: pair_rd_data = {byte_view[5], byte_view[6]};
            PSEL_SP: pair_rd_data = sp_q;
            PSEL_PC: pair_rd_data = pc_q;
            default: pair_rd_data = '0;
        endcase
    end

    AST_FLAG_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel == PSEL_AF) |-> pair_rd_data[FLAG_W-1:0] == '0); // R6
    AST_BAD_PAIR_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (pair_sel > PSEL_PC) |-> pair_rd_data == '0); // R8
    AST_BYTE_PORT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        !(pair_wr_en && pair_sel == PSEL_SP) |=> $stable(sp_q)); // R5
endmodule

// File: tb/sim_cpu_regfile.sv
module sim_cpu_regfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  byte_rd_sel = '0;
    logic [7:0]  byte_rd_data;
    logic        byte_wr_en = 1'b0;
    logic [2:0]  byte_wr_sel = '0;
    logic [7:0]  byte_wr_data = '0;
    logic [2:0]  pair_sel = '0;
    logic [15:0] pair_rd_data;
    logic        pair_wr_en = 1'b0;
    logic [15:0] pair_wr_data = '0;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0]  m [8];
    logic [15:0] m_sp, m_pc;

    always #10 clk = ~clk;

    cpu_regfile u0 (
        .clk(clk), .rst_n(rst_n),
        .byte_rd_sel(byte_rd_sel), .byte_rd_data(byte_rd_data),
        .byte_wr_en(byte_wr_en), .byte_wr_sel(byte_wr_sel), .byte_wr_data(byte_wr_data),
        .pair_sel(pair_sel), .pair_rd_data(pair_rd_data),
        .pair_wr_en(pair_wr_en), .pair_wr_data(pair_wr_data)
    );

    function automatic int hi_idx(int p);
        case (p) 0: return 0; 1: return 1; 2: return 3; default: return 5; endcase
    endfunction
    function automatic int lo_idx(int p);
        case (p) 0: return 7; 1: return 2; 2: return 4; default: return 6; endcase
    endfunction

    function automatic logic [15:0] exp_pair(int p);
        if (p < 4) return {m[hi_idx(p)], m[lo_idx(p)]};
        if (p == 4) return m_sp;
        if (p == 5) return m_pc;
        return 16'h0000;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 8; i++) m[i] = 8'h00;
        m_sp = 16'h0000;
        m_pc = 16'h0000;
    endtask

    task automatic check(string tag, logic [15:0] act, logic [15:0] exp, string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Sweep every read select and compare against the model
    task automatic verify_all(string tag);
        for (int s = 0; s < 8; s++) begin
            byte_rd_sel = 3'(s);
            #1;
            check(tag, {8'h00, byte_rd_data}, {8'h00, m[s]}, $sformatf("byte sel %0d", s));
        end
        for (int p = 0; p < 8; p++) begin
            pair_sel = 3'(p);
            #1;
            check(tag, pair_rd_data, exp_pair(p), $sformatf("pair sel %0d", p));
        end
    endtask

    task automatic step(bit bwe, logic [2:0] bs, logic [7:0] bd,
                        bit pwe, logic [2:0] ps, logic [15:0] pd);
        @(negedge clk);
        byte_wr_en = bwe; byte_wr_sel = bs; byte_wr_data = bd;
        pair_wr_en = pwe; pair_sel = ps; pair_wr_data = pd;
        @(posedge clk);
        if (bwe) m[bs] = (bs == 3'd7) ? (bd & 8'hF0) : bd;
        if (pwe && ps < 3'd4) begin
            m[hi_idx(int'(ps))] = pd[15:8];
            m[lo_idx(int'(ps))] = (ps == 3'd0) ? (pd[7:0] & 8'hF0) : pd[7:0];
        end
        if (pwe && ps == 3'd4) m_sp = pd;
        if (pwe && ps == 3'd5) m_pc = pd;
        #2;
        byte_wr_en = 1'b0;
        pair_wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: requirement all, actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        #2;
        verify_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        // R2 R9: every byte register, several values
        for (int i = 0; i < 7; i++) begin
            for (int k = 0; k < 3; k++) begin
                logic [7:0] v;
                v = (k == 0) ? 8'h5A : (k == 1) ? 8'hA5 : 8'(i * 37 + 1);
                step(1'b1, 3'(i), v, 1'b0, 3'd0, 16'h0000);
                verify_all("R2 R9");
            end
        end

        // R6: all flag byte values
        for (int v = 0; v < 256; v++) begin
            step(1'b1, 3'd7, 8'(v), 1'b0, 3'd0, 16'h0000);
            verify_all("R6");
        end

        // R3 R4: pair writes, then byte and pair views
        for (int p = 0; p < 4; p++) begin
            for (int k = 0; k < 3; k++) begin
                logic [15:0] v;
                v = (k == 0) ? 16'h1234 : (k == 1) ? 16'hFFFF : (16'h0F0F ^ 16'(p * 16'h1111));
                step(1'b0, 3'd0, 8'h00, 1'b1, 3'(p), v);
                verify_all("R3 R4 R6");
            end
        end

        // R5: SP and PC, then byte writes everywhere leave them alone
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd4, 16'hBEEF);
        verify_all("R5");
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd5, 16'h8001);
        verify_all("R5");
        for (int i = 0; i < 8; i++) begin
            step(1'b1, 3'(i), 8'hC3, 1'b0, 3'd0, 16'h0000);
            verify_all("R5");
        end

        // R7: every byte target against every pair target
        for (int b = 0; b < 8; b++) begin
            for (int p = 0; p < 6; p++) begin
                step(1'b1, 3'(b), 8'(8'h11 * b + 8'h0E), 1'b1, 3'(p), 16'(16'h9A70 + 16'(p * 16'h0103)));
                verify_all("R7");
            end
        end

        // R8: unused pair selects
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd6, 16'hDEAD);
        verify_all("R8");
        step(1'b0, 3'd0, 8'h00, 1'b1, 3'd7, 16'h7777);
        verify_all("R8");

        // R1: reset in mid-run
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        model_reset();
        #2;
        verify_all("R1");
        @(negedge clk);
        rst_n = 1'b1;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule